// File: doc/BRIEF.md
# Phase-Jerked Floppy Read Data Separator

This block turns the raw read pulses from a floppy drive into a recovered data window and a stream of data bits. It runs from an oversampling loop clock; the example operating point is a 16 MHz loop clock for a 500 kbit/s data rate. The raw pulse is asynchronous to that clock. It is synchronized, its leading edge is detected, and the edge is stretched into a hold of fixed length.

A free-running phase counter advances on every loop clock while the block is enabled. Each detected transition forces the counter back to zero. Phase alignment therefore comes from these hard jerks of the counter and not from a tuned oscillator. A window flip-flop changes level each time the counter climbs into its midpoint value. On every such change the block raises a one-cycle window-end strobe. Alongside the strobe it presents a bit that tells whether any transition was detected during the window that just closed. Decoding of the recording code and detection of sync marks belong to a later stage.

Top module: `pjl_separator`

## Requirements
- R1: While `rst_i` is high, or while `en_i` is low, `win_o`, `win_end_o` and `bit_o` are 0 and the phase counter is held at zero. Read pulses that arrive while `en_i` is low are not credited to any window.
- R2: With no read pulses, the first window end comes HALF = PHASE_STEPS/2 cycles after `en_i` rises. The counter then wraps from PHASE_STEPS-1 to 0, so later window ends follow every PHASE_STEPS cycles. With the default PHASE_STEPS = 16 they fall at cycles 8, 24 and 40.
- R3: `win_end_o` is high for exactly one cycle per window end. At each window end `win_o` inverts, starting from 0.
- R4: `bit_o` is 1 at a window end when at least one transition was detected in that window, however many there were. It is 0 for a window with none, so the accumulator is cleared for every new window.
- R5: Take the first clock edge at which the raw pulse is sampled high as edge k. The counter is forced to zero at edges k+3 and k+4. It then counts again, and the next window end is registered at edge k+4+HALF. With HALF = 8, a pulse sampled first at edge 1 after enabling gives a window end at edge 13.
- R6: The stretched hold lasts exactly two cycles whatever the width of the raw pulse. A raw pulse one cycle wide and one five cycles wide give the same window-end timing.
- R7: A transition detected in the same cycle as a window toggle is credited to the new window. The closing window reports 0 if it had no other transition.
- R8: While the hold is active the counter stays at zero, and no window toggle can take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Loop (oversampling) clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Loop enable; low clears and holds the loop |
| rd_raw_i | input | 1 | Raw read pulse from the drive, asynchronous, active high |
| win_o | output | 1 | Recovered data window level |
| win_end_o | output | 1 | One-cycle strobe when a window closes |
| bit_o | output | 1 | Data bit of the window just closed, valid with the strobe |

## Verification
The bench counts cycles from the rising enable to every window end, so the latency of the synchronizer and of the two-cycle hold is checked to the exact edge. One more or one fewer flop would shift the window end by a cycle. A stretch that follows the raw pulse width would move the window end when a long pulse is used. A transition timed to land in the same cycle as a toggle shows whether it is credited to the correct window: a design that gives it to the closing window reports 1 too early and 0 afterwards. A design that lets the hold block the toggle would also move the window end. Further tests check that pulses seen while disabled leave the first window empty, that a second pulse re-aligns the phase, and that the accumulator does not leak a 1 into the next window.

// File: rtl/pjl_pkg.sv
package pjl_pkg;

    // Length of the stretched transition hold, in loop clocks.
    localparam int unsigned HOLD_CYCLES = 2;

    // Registered state of the recovered window.
    typedef struct packed {
        logic level;   // window flip-flop
        logic strobe;  // one-cycle window-end pulse
        logic data;    // transition seen in the closed window
    } win_state_t;

    function automatic int unsigned cnt_width(input int unsigned steps);
        return (steps < 2) ? 1 : $clog2(steps);
    endfunction

endpackage

// File: rtl/pjl_pulse_sync.sv
module pjl_pulse_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic rise_o,
    output logic hold_o
);
    import pjl_pkg::*;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;
    logic [HOLD_CYCLES-1:0] hold_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        logic d;
        if (i == 0) begin : g_first
            assign d = raw_i;
        end else begin : g_next
            assign d = chain_q[i-1];
        end
        always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[i] <= 1'b0;
            else       chain_q[i] <= d;
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            last_q <= 1'b0;
            hold_q <= '0;
        end else begin
            last_q <= chain_q[SYNC_STAGES-1];
            hold_q <= {hold_q[HOLD_CYCLES-2:0], rise_o};
        end
    end

    assign hold_o = |hold_q;

endmodule

// File: rtl/pjl_phase_ctr.sv
module pjl_phase_ctr #(
    parameter int unsigned PHASE_STEPS = 16,
    localparam int unsigned CW = pjl_pkg::cnt_width(PHASE_STEPS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic          hold_i,
    output logic [CW-1:0] cnt_o,
    output logic          tog_o
);
    localparam int unsigned HALF = PHASE_STEPS / 2;
    localparam logic [CW-1:0] PRE_MID = CW'(HALF - 1);
    localparam logic [CW-1:0] LAST    = CW'(PHASE_STEPS - 1);

    logic [CW-1:0] cnt_q;

    assign tog_o = en_i & ~hold_i & (cnt_q == PRE_MID);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || hold_i) cnt_q <= '0;
        else if (cnt_q == LAST)       cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pjl_window.sv
module pjl_window (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  en_i,
    input  logic                  tog_i,
    input  logic                  rise_i,
    output pjl_pkg::win_state_t   st_o
);
    import pjl_pkg::*;

    win_state_t st_q;
    logic       acc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            st_q  <= '0;
            acc_q <= 1'b0;
        end else if (tog_i) begin
            st_q.level  <= ~st_q.level;
            st_q.strobe <= 1'b1;
            st_q.data   <= acc_q;
            acc_q       <= rise_i;   // same-cycle transition opens the new window
        end else begin
            st_q.strobe <= 1'b0;
            acc_q       <= acc_q | rise_i;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/pjl_separator.sv
module pjl_separator #(
    parameter int unsigned PHASE_STEPS = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic rd_raw_i,
    output logic win_o,
    output logic win_end_o,
    output logic bit_o
);
    import pjl_pkg::*;

    localparam int unsigned CW = cnt_width(PHASE_STEPS);

    logic          rise_w;
    logic          hold_w;
    logic          tog_w;
    logic [CW-1:0] cnt_w;
    win_state_t    st_w;

    pjl_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (rd_raw_i),
        .rise_o (rise_w),
        .hold_o (hold_w)
    );

    pjl_phase_ctr #(.PHASE_STEPS(PHASE_STEPS)) u_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .hold_i (hold_w),
        .cnt_o  (cnt_w),
        .tog_o  (tog_w)
    );

    pjl_window u_win (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .tog_i  (tog_w),
        .rise_i (rise_w),
        .st_o   (st_w)
    );

    assign win_o     = st_w.level;
    assign win_end_o = st_w.strobe;
    assign bit_o     = st_w.data;

endmodule

// File: rtl/pjl_separator_chk.sv
module pjl_separator_chk #(
    parameter int unsigned PHASE_STEPS = 16,
    localparam int unsigned CW = pjl_pkg::cnt_width(PHASE_STEPS)
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          en_i,
    input logic          hold_i,
    input logic [CW-1:0] cnt_i,
    input logic          win_i,
    input logic          strobe_i,
    input logic          bit_i
);
    // R1: a disabled loop stays cleared
    a_r1_idle_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (cnt_i == '0) && !strobe_i && !win_i && !bit_i);

    // R2: the counter never leaves its range
    a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_i <= CW'(PHASE_STEPS - 1));

    // R3: the strobe lasts a single cycle
    a_r3_strobe_single: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |=> !strobe_i);

    // R3: each strobe comes with a window level change
    a_r3_level_flips: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |-> (win_i != $past(win_i)));

    // R3: while enabled, the level changes only with a strobe
    a_r3_flip_needs_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && $past(en_i) && (win_i != $past(win_i))) |-> strobe_i);

    // R6: the stretched hold lasts at least two cycles
    a_r6_hold_two: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hold_i) |=> hold_i);

    // R8: the counter sits at zero after each held cycle
    a_r8_hold_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> (cnt_i == '0) && !strobe_i);
endmodule

bind pjl_separator pjl_separator_chk #(.PHASE_STEPS(PHASE_STEPS)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .hold_i   (hold_w),
    .cnt_i    (cnt_w),
    .win_i    (win_o),
    .strobe_i (win_end_o),
    .bit_i    (bit_o)
);

// File: tb/pjl_separator_bench.sv
module pjl_separator_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic rd  = 1'b0;
    logic win, wend, bitv;

    int checks   = 0;
    int fails    = 0;
    int raw_left = 0;
    int tcount   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pjl_separator u_pjl_separator (
        .clk_i     (clk),
        .rst_i     (rst),
        .en_i      (en),
        .rd_raw_i  (rd),
        .win_o     (win),
        .win_end_o (wend),
        .bit_o     (bitv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: advance to the next falling edge, update the raw pulse.
    task automatic tick();
        @(negedge clk);
        if (raw_left > 0) raw_left--;
        rd = (raw_left > 0);
        tcount++;
    endtask

    task automatic start_pulse(input int w);
        raw_left = w;
        rd = 1'b1;
    endtask

    task automatic begin_enabled();
        en = 1'b0;
        repeat (3) tick();
        en = 1'b1;
        tcount = 0;
    endtask

    task automatic wait_strobe(output int at, output int b, output int lvl);
        int guard = 0;
        tick();
        while (wend !== 1'b1 && guard < 100) begin
            tick();
            guard++;
        end
        at  = tcount;
        b   = int'(bitv);
        lvl = int'(win);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk("R1 reset win",    int'(win),  0);
        chk("R1 reset strobe", int'(wend), 0);
        chk("R1 reset bit",    int'(bitv), 0);
        rst = 1'b0;
    endtask

    task automatic t_disabled();
        int at, b, lvl, seen;
        en = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (i == 5 || i == 20) start_pulse(2);
            tick();
            if (wend || win) seen++;
        end
        chk("R1 no strobe while disabled", seen, 0);
        en = 1'b1;
        tcount = 0;
        wait_strobe(at, b, lvl);
        chk("R1 first window after enable time", at, 8);
        chk("R1 pulses while disabled not credited", b, 0);
    endtask

    task automatic t_freerun();
        int at, b, lvl;
        begin_enabled();
        wait_strobe(at, b, lvl);
        chk("R2 first window end", at, 8);
        chk("R3 level after first end", lvl, 1);
        tick();
        chk("R3 strobe one cycle", int'(wend), 0);
        wait_strobe(at, b, lvl);
        chk("R2 second window end", at, 24);
        chk("R3 level after second end", lvl, 0);
        chk("R4 empty window bit", b, 0);
        wait_strobe(at, b, lvl);
        chk("R2 wrap period", at, 40);
    endtask

    task automatic t_phase_jerk(input int width, input string tag);
        int at, b, lvl;
        begin_enabled();
        start_pulse(width);
        wait_strobe(at, b, lvl);
        chk({tag, " window end after pulse"}, at, 13);
        chk("R4 bit set by pulse", b, 1);
        wait_strobe(at, b, lvl);
        chk("R4 accumulator cleared", b, 0);
        chk("R5 free run after jerk", at, 29);
    endtask

    task automatic t_realign();
        int at, b, lvl;
        begin_enabled();
        start_pulse(1);
        repeat (4) tick();
        start_pulse(1);
        wait_strobe(at, b, lvl);
        chk("R5 second pulse realigns phase", at, 17);
        chk("R4 two pulses give one bit", b, 1);
    endtask

    task automatic t_same_cycle();
        int at, b, lvl;
        begin_enabled();
        repeat (5) tick();
        start_pulse(1);
        wait_strobe(at, b, lvl);
        chk("R7 toggle not blocked", at, 8);
        chk("R7 closing window bit", b, 0);
        wait_strobe(at, b, lvl);
        chk("R8 hold then resume", at, 18);
        chk("R7 new window credited", b, 1);
    endtask

    initial begin
        #(20 * 60000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_disabled();
        t_freerun();
        t_phase_jerk(1, "R5");
        t_phase_jerk(5, "R6");
        t_realign();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule